// File: doc/BRIEF.md
# Pattern-Lock Bit Error Rate Receiver

This block checks a serial bit stream against the pseudo-random sequence x^15 + x^14 + 1 (period 2^15 - 1). A `bitEn` pulse marks each valid bit. To find the pattern, the block loads its local generator with 15 received bits. It then lets the generator run on its own and compares each predicted bit with the incoming bit. The receiver declares lock after 32 consecutive agreements. While locked, it counts the bits it receives and the bits that disagree with the prediction. A burst of errors drops it back into the hunt.

A separate pair of detectors watches the raw stream for long runs of ones and of zeros. Every noteworthy event sets a sticky bit in an 8-bit status byte. Software clears a status bit by writing 1 to it. The interrupt line is high while any status bit that `intEn` enables is set.

Top module: `bert_rx`

## Requirements
- R1: After 15 bits have loaded the generator, 32 consecutive correct bits put the receiver in lock. `locked` then goes high and status bit 0 (sync event) is set, on the edge that takes in the 32nd bit.
- R2: A wrong bit during the 32-bit verification restarts the 15-bit load. This restart does not set status bit 1.
- R3: Only while locked, each bit increments `bitCount`. Each wrong bit also increments `errCount` and sets status bit 6. Bits taken outside lock change neither counter.
- R4: While locked, the receiver returns to the hunt and sets status bit 1 (loss event) when the bit just taken makes 6 or more errors within the last 64 locked bits. Five errors in any 64-bit span keep the lock.
- R5: When `bitCount` wraps from all ones to zero, status bit 5 is set.
- R6: When `errCount` wraps from all ones to zero, status bit 4 is set.
- R7: Status bit 3 is set on the 32nd consecutive received one, and status bit 2 on the 32nd consecutive received zero. Each is set once per run; a longer run does not set the bit again.
- R8: Reset clears the status byte, both counters and `locked`. Status bit 7 always reads 0.
- R9: Pulsing `clrWr` clears the status bits marked with 1 in `clrMask`. A new event on a bit in the same cycle as its clear leaves that bit set.
- R10: `irq` is high exactly while some status bit is set whose `intEn` bit is 1.
- R11: A cycle with `bitEn` low changes no state, whatever `rxBit` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitEn | input | 1 | Marks the cycle that carries a valid received bit |
| rxBit | input | 1 | Received data bit |
| clrWr | input | 1 | Strobe for write-one-to-clear of status |
| clrMask | input | 8 | Status bits to clear when `clrWr` is high |
| intEn | input | 8 | Per-bit interrupt enable for the status byte |
| bitCount | output | BIT_W | Bits received while locked |
| errCount | output | ERR_W | Bit errors seen while locked |
| status | output | 8 | Sticky event byte |
| locked | output | 1 | High while the receiver holds pattern lock |
| irq | output | 1 | Interrupt request |

## Verification
The bench probes the edges of the error window. Five errors followed by 59 clean bits and one more error must keep the lock. The same pattern with 58 clean bits must drop it, so an off-by-one in the window or the threshold shows up as a wrong `locked` value. A corrupted bit inside the verification phase must restart the hunt without a loss event; a design that treats it as loss of lock would report bit 1. The bench shrinks the counters so that both wraps happen in a short run. It then checks the wrapped value and the overflow flags, which catches a counter that saturates or flags one bit late. The run detectors are fed with idle cycles that carry the opposite bit. A clear is applied in the same cycle as a run event, so ignoring `bitEn` or letting the clear win both produce a wrong status byte.

// File: rtl/bert_pkg.sv
package bert_pkg;

  typedef enum logic [1:0] {
    ST_SEED   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCK   = 2'd2
  } huntState_t;

  // strobes from the control FSM to the datapath, all qualified by bitEn
  typedef struct packed {
    logic loadRx;    // shift the received bit into the generator
    logic freeRun;   // advance the generator with its own prediction
    logic cntBit;    // count one locked bit
    logic cntErr;    // count one locked error
    logic evtSync;   // lock declared this cycle
    logic evtLoss;   // lock dropped this cycle
  } bertStrobe_t;

  localparam int unsigned FLAG_SYNC   = 0;
  localparam int unsigned FLAG_LOSS   = 1;
  localparam int unsigned FLAG_ZEROS  = 2;
  localparam int unsigned FLAG_ONES   = 3;
  localparam int unsigned FLAG_ERROVF = 4;
  localparam int unsigned FLAG_BITOVF = 5;
  localparam int unsigned FLAG_BITERR = 6;

endpackage

// File: rtl/bert_rx_ctrl.sv
module bert_rx_ctrl
  import bert_pkg::*;
#(
  parameter int unsigned SEED_LEN  = 15,
  parameter int unsigned SYNC_LEN  = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_LIMIT = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bitEn,
  input  logic        mismatch,
  output bertStrobe_t stb,
  output logic        locked
);

  localparam int unsigned SEED_W  = $clog2(SEED_LEN);
  localparam int unsigned MATCH_W = $clog2(SYNC_LEN);
  localparam int unsigned WCNT_W  = $clog2(WIN_LEN + 1);

  huntState_t           stateQ, stateD;
  logic [SEED_W-1:0]    seedQ, seedD;
  logic [MATCH_W-1:0]   matchQ, matchD;
  logic [WIN_LEN-1:0]   histQ, histD;
  logic [WCNT_W-1:0]    winQ, winD, winNext;

  always_comb begin
    stateD  = stateQ;
    seedD   = seedQ;
    matchD  = matchQ;
    histD   = histQ;
    winD    = winQ;
    stb     = '0;
    winNext = winQ + WCNT_W'(mismatch) - WCNT_W'(histQ[WIN_LEN-1]);
    case (stateQ)
      ST_SEED: begin
        if (bitEn) begin
          stb.loadRx = 1'b1;
          if (seedQ == SEED_W'(SEED_LEN - 1)) begin
            stateD = ST_VERIFY;
            seedD  = '0;
            matchD = '0;
          end else begin
            seedD = seedQ + 1'b1;
          end
        end
      end
      ST_VERIFY: begin
        if (bitEn) begin
          if (mismatch) begin
            stateD = ST_SEED;
            seedD  = '0;
          end else begin
            stb.freeRun = 1'b1;
            if (matchQ == MATCH_W'(SYNC_LEN - 1)) begin
              stateD      = ST_LOCK;
              stb.evtSync = 1'b1;
              histD       = '0;
              winD        = '0;
            end else begin
              matchD = matchQ + 1'b1;
            end
          end
        end
      end
      ST_LOCK: begin
        if (bitEn) begin
          stb.freeRun = 1'b1;
          stb.cntBit  = 1'b1;
          stb.cntErr  = mismatch;
          histD       = {histQ[WIN_LEN-2:0], mismatch};
          winD        = winNext;
          if (winNext >= WCNT_W'(ERR_LIMIT)) begin
            stateD      = ST_SEED;
            seedD       = '0;
            stb.evtLoss = 1'b1;
          end
        end
      end
      default: stateD = ST_SEED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_SEED;
      seedQ  <= '0;
      matchQ <= '0;
      histQ  <= '0;
      winQ   <= '0;
    end else begin
      stateQ <= stateD;
      seedQ  <= seedD;
      matchQ <= matchD;
      histQ  <= histD;
      winQ   <= winD;
    end
  end

  assign locked = (stateQ == ST_LOCK);

  // R1: lock is only entered from verification after the full match run
  p_lock_after_matches_r1: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOCK && $past(stateQ) != ST_LOCK) |->
      ($past(stateQ) == ST_VERIFY && $past(matchQ) == MATCH_W'(SYNC_LEN - 1) && $past(bitEn)));

  // R4: a locked state never holds an error tally at the limit
  p_window_below_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_LOCK) |-> (winQ < WCNT_W'(ERR_LIMIT)));

  // R11: idle cycles leave the hunt state untouched
  p_idle_holds_state_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!bitEn) |=> ($stable(stateQ) && $stable(seedQ) && $stable(matchQ) && $stable(winQ)));

  // R2: leaving verification for the seed phase never reports a loss event
  p_verify_retry_silent_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_VERIFY) |-> !stb.evtLoss);

endmodule

// File: rtl/bert_rx_dp.sv
module bert_rx_dp
  import bert_pkg::*;
#(
  parameter int unsigned LFSR_W  = 15,
  parameter int unsigned TAP_A   = 15,
  parameter int unsigned TAP_B   = 14,
  parameter int unsigned BIT_W   = 32,
  parameter int unsigned ERR_W   = 24,
  parameter int unsigned RUN_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             rxBit,
  input  bertStrobe_t      stb,
  input  logic             clrWr,
  input  logic [7:0]       clrMask,
  output logic             mismatch,
  output logic [BIT_W-1:0] bitCnt,
  output logic [ERR_W-1:0] errCnt,
  output logic [7:0]       statQ
);

  localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);

  logic [LFSR_W-1:0] lfsrQ;
  logic              expBit;
  logic              bitWrap, errWrap;
  logic [1:0]        runHit;
  logic [7:0]        evtVec, clrVec;

  assign expBit   = lfsrQ[TAP_A-1] ^ lfsrQ[TAP_B-1];
  assign mismatch = rxBit ^ expBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= '0;
    end else if (stb.loadRx) begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], rxBit};
    end else if (stb.freeRun) begin
      lfsrQ <= {lfsrQ[LFSR_W-2:0], expBit};
    end
  end

  assign bitWrap = stb.cntBit && (&bitCnt);
  assign errWrap = stb.cntErr && (&errCnt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      errCnt <= '0;
    end else begin
      if (stb.cntBit) bitCnt <= bitCnt + 1'b1;
      if (stb.cntErr) errCnt <= errCnt + 1'b1;
    end
  end

  // one saturating run detector per polarity: index 0 watches zeros, 1 ones
  for (genvar g = 0; g < 2; g++) begin : g_run
    logic [RUN_W-1:0] runQ;
    assign runHit[g] = bitEn && (rxBit == 1'(g)) && (runQ == RUN_W'(RUN_LEN - 1));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runQ <= '0;
      end else if (bitEn) begin
        if (rxBit == 1'(g)) begin
          if (runQ != RUN_W'(RUN_LEN)) runQ <= runQ + 1'b1;
        end else begin
          runQ <= '0;
        end
      end
    end
  end

  always_comb begin
    evtVec              = '0;
    evtVec[FLAG_SYNC]   = stb.evtSync;
    evtVec[FLAG_LOSS]   = stb.evtLoss;
    evtVec[FLAG_ZEROS]  = runHit[0];
    evtVec[FLAG_ONES]   = runHit[1];
    evtVec[FLAG_ERROVF] = errWrap;
    evtVec[FLAG_BITOVF] = bitWrap;
    evtVec[FLAG_BITERR] = stb.cntErr;
  end

  assign clrVec = clrWr ? clrMask : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrVec) | evtVec;
  end

  // R9: a set bit only falls when its clear was requested
  p_sticky_until_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(statQ) & ~$past(clrVec) & ~statQ) == 8'h00));

  // R6: a wrap of the error counter leaves its overflow flag raised
  p_errwrap_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == '0 && $past(errCnt) != '0) |-> statQ[FLAG_ERROVF]);

  // R3: the error counter moves only on a locked error strobe
  p_err_only_locked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt != $past(errCnt)) |-> $past(stb.cntErr));

  // R5: a wrap of the bit counter leaves its overflow flag raised
  p_bitwrap_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (bitCnt == '0 && $past(bitCnt) != '0) |-> statQ[FLAG_BITOVF]);

endmodule

// File: rtl/bert_rx.sv
module bert_rx
  import bert_pkg::*;
#(
  parameter int unsigned BIT_W     = 32,
  parameter int unsigned ERR_W     = 24,
  parameter int unsigned LFSR_W    = 15,
  parameter int unsigned TAP_A     = 15,
  parameter int unsigned TAP_B     = 14,
  parameter int unsigned SYNC_LEN  = 32,
  parameter int unsigned RUN_LEN   = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_LIMIT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitEn,
  input  logic             rxBit,
  input  logic             clrWr,
  input  logic [7:0]       clrMask,
  input  logic [7:0]       intEn,
  output logic [BIT_W-1:0] bitCount,
  output logic [ERR_W-1:0] errCount,
  output logic [7:0]       status,
  output logic             locked,
  output logic             irq
);

  bertStrobe_t stb;
  logic        mismatch;

  bert_rx_ctrl #(
    .SEED_LEN (LFSR_W),
    .SYNC_LEN (SYNC_LEN),
    .WIN_LEN  (WIN_LEN),
    .ERR_LIMIT(ERR_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .mismatch(mismatch),
    .stb     (stb),
    .locked  (locked)
  );

  bert_rx_dp #(
    .LFSR_W (LFSR_W),
    .TAP_A  (TAP_A),
    .TAP_B  (TAP_B),
    .BIT_W  (BIT_W),
    .ERR_W  (ERR_W),
    .RUN_LEN(RUN_LEN)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .bitEn   (bitEn),
    .rxBit   (rxBit),
    .stb     (stb),
    .clrWr   (clrWr),
    .clrMask (clrMask),
    .mismatch(mismatch),
    .bitCnt  (bitCount),
    .errCnt  (errCount),
    .statQ   (status)
  );

  assign irq = |(status & intEn);

endmodule

// File: tb/bert_rx_test.sv
module bert_rx_test;

  localparam int unsigned BIT_W = 10;
  localparam int unsigned ERR_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             bitEn = 1'b0;
  logic             rxBit = 1'b0;
  logic             clrWr = 1'b0;
  logic [7:0]       clrMask = 8'h00;
  logic [7:0]       intEn = 8'h00;
  logic [BIT_W-1:0] bitCount;
  logic [ERR_W-1:0] errCount;
  logic [7:0]       status;
  logic             locked;
  logic             irq;

  int checks = 0;
  int errors = 0;
  int expBits = 0;
  int expErrs = 0;
  bit expLocked = 1'b0;
  logic [14:0] gen = 15'h0001;

  always #10 clk = ~clk;

  bert_rx #(.BIT_W(BIT_W), .ERR_W(ERR_W)) uut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rxBit(rxBit),
    .clrWr(clrWr), .clrMask(clrMask), .intEn(intEn),
    .bitCount(bitCount), .errCount(errCount), .status(status),
    .locked(locked), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one valid bit followed by one idle cycle carrying the opposite value
  task automatic sendBit(input logic b);
    @(negedge clk);
    bitEn = 1'b1;
    rxBit = b;
    @(negedge clk);
    bitEn = 1'b0;
    rxBit = ~b;
  endtask

  function automatic logic genNext();
    logic b;
    b = gen[14] ^ gen[13];
    gen = {gen[13:0], b};
    return b;
  endfunction

  task automatic sendGood(input int n);
    for (int i = 0; i < n; i++) begin
      sendBit(genNext());
      if (expLocked) expBits++;
    end
  endtask

  task automatic sendBad(input int n);
    for (int i = 0; i < n; i++) begin
      sendBit(~genNext());
      if (expLocked) begin
        expBits++;
        expErrs++;
      end
    end
  endtask

  task automatic clearBits(input logic [7:0] m);
    @(negedge clk);
    clrWr = 1'b1;
    clrMask = m;
    @(negedge clk);
    clrWr = 1'b0;
    clrMask = 8'h00;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    doReset();
    // R8 reset state
    check("R8 status", 32'(status), 32'h00);
    check("R8 bitCount", 32'(bitCount), 32'd0);
    check("R8 errCount", 32'(errCount), 32'd0);
    check("R8 locked", 32'(locked), 32'd0);
    check("R10 irq reset", 32'(irq), 32'd0);

    // R1: seed 15, then 31 matches leave it unlocked, the 32nd locks
    sendGood(15 + 31);
    check("R1 locked before 32nd", 32'(locked), 32'd0);
    check("R1 status before 32nd", 32'(status), 32'h00);
    sendGood(1);
    expLocked = 1'b1;
    check("R1 locked", 32'(locked), 32'd1);
    check("R1 sync flag", 32'(status), 32'h01);
    check("R3 no bits counted in hunt", 32'(bitCount), 32'd0);

    // R3 counting clean bits
    sendGood(20);
    check("R3 bitCount", 32'(bitCount), 32'(expBits % 1024));
    check("R3 errCount clean", 32'(errCount), 32'd0);

    // R10 interrupt enable
    @(negedge clk); intEn = 8'h01; #1;
    check("R10 irq enabled", 32'(irq), 32'd1);
    @(negedge clk); intEn = 8'h02; #1;
    check("R10 irq masked", 32'(irq), 32'd0);
    intEn = 8'h00;

    // R9 write-one-to-clear
    clearBits(8'h01);
    check("R9 clear", 32'(status), 32'h00);

    // R4 five errors then one 64 bits after the first: stays locked
    sendBad(5);
    sendGood(59);
    sendBad(1);
    check("R4 keep lock", 32'(locked), 32'd1);
    check("R3 errCount", 32'(errCount), 32'(expErrs % 16));
    check("R3 error flag", 32'(status), 32'h40);
    sendGood(64);
    clearBits(8'h40);

    // R4 sixth error inside a 64-bit span drops lock
    sendBad(5);
    sendGood(58);
    sendBad(1);
    expLocked = 1'b0;
    check("R4 drop lock", 32'(locked), 32'd0);
    check("R4 loss flag", 32'(status), 32'h42);
    check("R3 bitCount at drop", 32'(bitCount), 32'(expBits % 1024));
    check("R3 errCount at drop", 32'(errCount), 32'(expErrs % 16));

    // R2 mismatch during verification restarts silently
    clearBits(8'hFF);
    sendGood(15 + 10);
    sendBad(1);
    check("R2 not locked", 32'(locked), 32'd0);
    check("R2 no loss flag", 32'(status), 32'h00);
    check("R3 hunt bits not counted", 32'(bitCount), 32'(expBits % 1024));
    sendGood(15 + 32);
    expLocked = 1'b1;
    check("R2 relock", 32'(locked), 32'd1);
    check("R1 sync flag again", 32'(status), 32'h01);

    // R6 error counter wraps (12 + 4 = 16)
    sendBad(4);
    check("R6 errCount wrapped", 32'(errCount), 32'd0);
    check("R6 overflow flag", 32'(status), 32'h51);
    check("R4 four errors keep lock", 32'(locked), 32'd1);

    // R5 bit counter wraps at 1024
    sendGood(1023 - expBits);
    check("R5 bitCount max", 32'(bitCount), 32'd1023);
    check("R5 no flag yet", 32'(status[5]), 32'd0);
    sendGood(1);
    check("R5 bitCount wrapped", 32'(bitCount), 32'd0);
    check("R5 overflow flag", 32'(status), 32'h71);

    // R7 / R9 / R11 run detectors with idle cycles of opposite value
    doReset();
    for (int i = 0; i < 31; i++) sendBit(1'b1);
    check("R11 R7 31 ones", 32'(status), 32'h00);
    @(negedge clk);
    bitEn = 1'b1; rxBit = 1'b1; clrWr = 1'b1; clrMask = 8'h08;
    @(negedge clk);
    bitEn = 1'b0; rxBit = 1'b0; clrWr = 1'b0; clrMask = 8'h00;
    check("R9 event beats clear", 32'(status), 32'h08);
    clearBits(8'h08);
    sendBit(1'b1);
    check("R7 once per run", 32'(status), 32'h00);
    for (int i = 0; i < 31; i++) sendBit(1'b0);
    check("R7 31 zeros", 32'(status), 32'h00);
    sendBit(1'b0);
    check("R7 zeros flag", 32'(status), 32'h04);
    check("R11 no count while hunting", 32'(bitCount), 32'd0);
    @(negedge clk); intEn = 8'h04; #1;
    check("R10 irq on zeros", 32'(irq), 32'd1);

    finishRun();
  end

endmodule